// File: doc/BRIEF.md
# Prescaled Period-Match PWM Time Base

This block is a 10-bit up-counter that serves as the time base for a PWM channel. A selectable prescaler divides the oscillator clock and paces the counter. The counter advances by one on each prescaler tick. When it reaches a programmable period value, the counter returns to zero and a sticky match flag is raised on that same clock edge.

Software programs the period over a narrow write bus, in a low byte and a two-bit high part. It chooses one of four prescale ratios and turns counting on or off with an enable bit. A PWM duty comparator can watch the running count. An interrupt source watches the flag, and software clears the flag with a clear input. For a second channel, instantiate the block a second time.

Reset is asynchronous and active-low. It is asserted at once and released through a two-stage synchronizer.

Top module: `pwm_timebase`

## Requirements
- R1: While enabled, the 10-bit count rises by exactly one on every prescaler tick that is not a period match, and keeps its value between ticks.
- R2: `psc_sel` selects the prescale ratio: 00 gives 1:2, 01 gives 1:8, 10 gives 1:32 and 11 gives 1:64. Starting from reset with period P, the first match lands on the (P+1)*ratio-th enabled clock edge.
- R3: On a tick where the count equals the period, the count returns to 0 instead of incrementing.
- R4: The match flag is set on the same edge that returns the count to 0, so both are seen together after that edge.
- R5: Once set, the match flag stays set, even with the timer disabled, until `flag_clr` is high at a clock edge with no new match, which clears it.
- R6: When a match and `flag_clr` coincide on one edge, the flag ends up set.
- R7: While `tmr_en` is low, the count and the prescaler phase hold, and no new match flag is raised. Counting resumes from the held phase when the enable returns.
- R8: With a period of 0, the count stays at 0 and a match occurs on every prescaler tick.
- R9: A write with `prd_we` high updates the period. With `prd_hi_sel` low, bits 7:0 take `prd_wdata[7:0]`. With `prd_hi_sel` high, bits 9:8 take `prd_wdata[1:0]`, the other data bits are ignored, and the low byte is kept.
- R10: Reset clears the count, the prescaler phase, the period register and the match flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Counting enable |
| psc_sel | input | 2 | Prescale ratio select |
| prd_we | input | 1 | Period write strobe |
| prd_hi_sel | input | 1 | Selects the high part (1) or low byte (0) of the period |
| prd_wdata | input | 8 | Period write data |
| flag_clr | input | 1 | Clears the match flag |
| cnt_o | output | 10 | Current time-base count |
| match_flag | output | 1 | Sticky period-match flag |

## Verification
The assertions assume that `psc_sel` and the period are changed only while the timer is disabled. This keeps the minimum spacing between ticks and keeps the count from running past a shortened period. The directed stimulus follows that rule. It programs the period and ratio with `tmr_en` low and enables the timer only afterwards. The assertions also assume a clean reset release, so the bench releases reset on a falling clock edge and then waits out the synchronizer before driving any stimulus.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int CNT_W  = 10;
  localparam int BUS_W  = 8;
  localparam int HI_W   = CNT_W - BUS_W;
  localparam int PSC_W  = 6;

  typedef enum logic [1:0] {
    DIV_2  = 2'b00,
    DIV_8  = 2'b01,
    DIV_32 = 2'b10,
    DIV_64 = 2'b11
  } psc_ratio_e;

  // terminal value of the prescaler phase counter for each ratio
  function automatic logic [PSC_W-1:0] div_limit(input logic [1:0] sel);
    logic [PSC_W-1:0] lim;
    unique case (psc_ratio_e'(sel))
      DIV_2:   lim = PSC_W'(1);
      DIV_8:   lim = PSC_W'(7);
      DIV_32:  lim = PSC_W'(31);
      default: lim = PSC_W'(63);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/ptb_rst_sync.sv
module ptb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler
  import ptb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PSC_W-1:0] phase_q, phase_d;
  logic [PSC_W-1:0] lim;

  always_comb begin
    lim     = div_limit(sel);
    tick    = en && (phase_q >= lim);
    phase_d = phase_q;
    if (en) phase_d = tick ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // smallest ratio is 1:2, so ticks never land on adjacent cycles
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(phase_q));
endmodule

// File: rtl/ptb_period_reg.sv
module ptb_period_reg
  import ptb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             hi_sel,
  input  logic [BUS_W-1:0] wdata,
  output logic [CNT_W-1:0] period
);
  logic [BUS_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (we) begin
      if (hi_sel) hi_d = wdata[HI_W-1:0];
      else        lo_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign period = {hi_q, lo_q};

  p_hi_keeps_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hi_sel) |=> period[BUS_W-1:0] == $past(period[BUS_W-1:0]));
  p_lo_keeps_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hi_sel) |=> period[CNT_W-1:BUS_W] == $past(period[CNT_W-1:BUS_W]));
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import ptb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    match = tick && (cnt_q == period);
    cnt_d = cnt_q;
    if (match)     cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != period) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == period) |=> cnt_q == '0);
endmodule

// File: rtl/ptb_flag.sv
module ptb_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import ptb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic [1:0]       psc_sel,
  input  logic             prd_we,
  input  logic             prd_hi_sel,
  input  logic [BUS_W-1:0] prd_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_flag
);
  logic             rst_sync_n;
  logic             tick;
  logic             match;
  logic [CNT_W-1:0] period;

  ptb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ptb_prescaler u_psc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (tmr_en),
    .sel   (psc_sel),
    .tick  (tick)
  );

  ptb_period_reg u_prd (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (prd_we),
    .hi_sel (prd_hi_sel),
    .wdata  (prd_wdata),
    .period (period)
  );

  ptb_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .period (period),
    .cnt    (cnt_o),
    .match  (match)
  );

  ptb_flag u_flag (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (match),
    .clr   (flag_clr),
    .flag  (match_flag)
  );

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tmr_en && !match_flag) |=> !match_flag);
  p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tmr_en |=> $stable(cnt_o));
  p_match_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match |=> (cnt_o == '0 && match_flag));
endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tmr_en;
  logic [1:0] psc_sel;
  logic       prd_we;
  logic       prd_hi_sel;
  logic [7:0] prd_wdata;
  logic       flag_clr;
  logic [9:0] cnt_o;
  logic       match_flag;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwm_timebase u_pwm_timebase (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_en     (tmr_en),
    .psc_sel    (psc_sel),
    .prd_we     (prd_we),
    .prd_hi_sel (prd_hi_sel),
    .prd_wdata  (prd_wdata),
    .flag_clr   (flag_clr),
    .cnt_o      (cnt_o),
    .match_flag (match_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tmr_en = 1'b0; psc_sel = 2'b00; prd_we = 1'b0;
    prd_hi_sel = 1'b0; prd_wdata = '0; flag_clr = 1'b0;
    edges(3);
    rst_n = 1'b1;
    edges(4);
  endtask

  task automatic write_prd(input logic hi, input logic [7:0] d);
    prd_we = 1'b1; prd_hi_sel = hi; prd_wdata = d;
    @(negedge clk);
    prd_we = 1'b0;
  endtask

  // enabled edges until the flag shows up
  task automatic run_to_flag(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!match_flag && n < 5000);
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 count after reset", int'(cnt_o), 0);
    check("R10 flag after reset", int'(match_flag), 0);
  endtask

  task automatic t_ratios();
    int n;
    int div [4] = '{2, 8, 32, 64};
    for (int s = 0; s < 4; s++) begin
      do_reset();
      write_prd(1'b0, 8'd5);
      psc_sel = 2'(s);
      tmr_en = 1'b1;
      run_to_flag(n);
      check($sformatf("R2 cycles to match sel=%0d", s), n, 6 * div[s]);
      check("R3 count wrapped to zero", int'(cnt_o), 0);
      check("R4 flag with wrap", int'(match_flag), 1);
    end
  endtask

  task automatic t_count();
    do_reset();
    write_prd(1'b1, 8'h03);
    write_prd(1'b0, 8'hFF);
    tmr_en = 1'b1;
    edges(20);
    check("R1 count after 20 edges at 1:2", int'(cnt_o), 10);
    edges(1);
    check("R1 count holds between ticks", int'(cnt_o), 10);
  endtask

  task automatic t_hold();
    int n;
    do_reset();
    write_prd(1'b0, 8'd3);
    psc_sel = 2'b01;
    tmr_en = 1'b1;
    edges(13);
    tmr_en = 1'b0;
    edges(50);
    check("R7 count held while disabled", int'(cnt_o), 1);
    check("R7 no flag while disabled", int'(match_flag), 0);
    tmr_en = 1'b1;
    run_to_flag(n);
    check("R7 prescaler phase kept", n, 19);
  endtask

  task automatic t_sticky();
    tmr_en = 1'b0;
    edges(10);
    check("R5 flag stays set", int'(match_flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R5 flag cleared", int'(match_flag), 0);
  endtask

  task automatic t_setwins();
    do_reset();
    flag_clr = 1'b1;
    tmr_en = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check($sformatf("R6 flag edge %0d", k), int'(match_flag), (k % 2 == 0) ? 1 : 0);
      check("R8 count pinned at 0", int'(cnt_o), 0);
    end
    flag_clr = 1'b0;
  endtask

  task automatic t_period0();
    int n;
    do_reset();
    psc_sel = 2'b11;
    tmr_en = 1'b1;
    run_to_flag(n);
    check("R8 zero period at 1:64", n, 64);
  endtask

  task automatic t_write();
    int n;
    do_reset();
    write_prd(1'b0, 8'h34);
    write_prd(1'b1, 8'hFE);
    tmr_en = 1'b1;
    run_to_flag(n);
    check("R9 split period 0x234", n, 565 * 2);
    do_reset();
    write_prd(1'b1, 8'h01);
    write_prd(1'b0, 8'h02);
    write_prd(1'b1, 8'h00);
    tmr_en = 1'b1;
    run_to_flag(n);
    check("R9 high rewrite keeps low byte", n, 3 * 2);
  endtask

  task automatic t_reset_mid();
    int n;
    do_reset();
    write_prd(1'b0, 8'd9);
    tmr_en = 1'b1;
    run_to_flag(n);
    edges(5);
    #2 rst_n = 1'b0;
    #1;
    check("R10 async count clear", int'(cnt_o), 0);
    check("R10 async flag clear", int'(match_flag), 0);
    tmr_en = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(4);
    tmr_en = 1'b1;
    run_to_flag(n);
    check("R10 period cleared by reset", n, 2);
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_count();
    t_hold();
    t_sticky();
    t_setwins();
    t_period0();
    t_write();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule